// File: doc/BRIEF.md
# Memory-Mapped Parallel Printer Port

This block connects a byte-wide parallel printer to a simple memory-mapped CPU bus. The bus carries an address, write data, read data and separate read and write strobes. The block watches the address and claims three fixed word locations: a character register that software writes and can read back, a status register that shows lines coming back from the printer, and a control register that drives handshake lines out to the printer.

Software sends a character by writing it to the character register. It polls the ready bit in the status register before each write, and raises the data-available line through the control register. Printer status lines are asynchronous to the bus clock, so each one passes through a two-flop synchronizer before a read can see it. Read data is registered. It comes back one cycle after the read strobe, together with a valid flag that rises only for addresses the block owns.

Top module: `prn_port`

## Requirements
- R1: While the reset is held, and until the first bus cycle after its synchronized release, the character byte, all three control outputs, `bus_rvalid` and `bus_rdata` are zero.
- R2: A write (`bus_wr`=1) to address 0xFFE0 stores `bus_wdata[7:0]` into the character register. `prn_data` shows it from the next cycle, and `bus_wdata[15:8]` is ignored.
- R3: A read (`bus_rd`=1) of 0xFFE0 returns the stored character on `bus_rdata[7:0]`, with bits 15:8 zero and `bus_rvalid`=1, in the cycle after the strobe. A read with no write strobe leaves the register unchanged.
- R4: A read of 0xFFE2 returns status in the following cycle: bit 0 is ready (1 = printer can take a character), bit 1 is off-line and bit 2 is paper-out, all taken from the inputs as they stood two clock edges earlier. Bits 15:3 read zero.
- R5: A write to 0xFFE2 has no effect: the character and control outputs keep their values.
- R6: A write to 0xFFE8 stores `bus_wdata[2:0]` into the control register. Bit 0 drives `prn_strobe`, bit 1 drives `prn_init` and bit 2 drives `prn_select`, visible from the next cycle. Bits 15:3 are ignored.
- R7: A read of 0xFFE8 gives `bus_rvalid`=1 and `bus_rdata`=0 in the following cycle. The control contents are never returned.
- R8: A read of any other address gives `bus_rvalid`=0 and `bus_rdata`=0. A write to any other address changes no output.
- R9: `bus_rvalid` is 1 only in the cycle after a read strobe to one of the three claimed addresses. Whenever `bus_rvalid` is 0, `bus_rdata` is zero.
- R10: When read and write strobes hit 0xFFE0 in the same cycle, the read returns the character held before that write, and the new character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid for a claimed address |
| prn_data | output | 8 | Character byte to the printer |
| prn_strobe | output | 1 | Data-available line |
| prn_init | output | 1 | Initialise line |
| prn_select | output | 1 | Printer select line |
| prn_ready_in | input | 1 | Printer can accept a character |
| prn_offline_in | input | 1 | Printer is off-line |
| prn_paperout_in | input | 1 | Printer is out of paper |

## Verification
The bench targets near-miss addresses such as 0xFFE1, 0xFFE4 and 0xFFE9. A decoder that compared only some address bits would claim these and raise the valid flag or overwrite a register. It writes to the status address and writes with all-ones upper data bits. A design that let the status address reach a latch, or that took too many data bits, would change the printer outputs. It changes status inputs and reads them back at once and again two cycles later. A design with too few or too many synchronizer flops would return the new value early or late. It also issues a read and a write to the character address in the same cycle. A design that forwarded the write data would return the new character instead of the old one.

// File: rtl/prn_pkg.sv
package prn_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CHAR = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } prn_sel_e;

  typedef struct packed {
    logic paper_out;
    logic offline;
    logic ready;
  } prn_stat_t;

  typedef struct packed {
    logic select;
    logic init;
    logic strobe;
  } prn_ctrl_t;

  localparam int STAT_W = $bits(prn_stat_t);
  localparam int CTRL_W = $bits(prn_ctrl_t);

endpackage

// File: rtl/prn_rst_sync.sv
module prn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic hold1_q, hold2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold1_q <= 1'b0;
      hold2_q <= 1'b0;
    end else begin
      hold1_q <= 1'b1;
      hold2_q <= hold1_q;
    end
  end

  assign rst_n_sync = hold2_q;
endmodule

// File: rtl/prn_decode.sv
module prn_decode
  import prn_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_CHAR = 16'hFFE0,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 16'hFFE2,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 16'hFFE8
) (
  input  logic [ADDR_W-1:0] addr,
  output prn_sel_e          sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_CHAR)      sel = SEL_CHAR;
    else if (addr == ADDR_STAT) sel = SEL_STAT;
    else if (addr == ADDR_CTRL) sel = SEL_CTRL;
  end
endmodule

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      assign stage_d[gi] = d;
    end else begin : g_next
      assign stage_d[gi] = stage_q[gi-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[gi] <= '0;
      else        stage_q[gi] <= stage_d[gi];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/prn_regs.sv
module prn_regs
  import prn_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  prn_sel_e          sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  prn_stat_t         stat_sync,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [CHAR_W-1:0] char_out,
  output prn_ctrl_t         ctrl_out
);
  logic [CHAR_W-1:0] char_q, char_d;
  prn_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  logic              char_en, ctrl_en;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CHAR_W];

  assign char_en = wr && (sel == SEL_CHAR);
  assign ctrl_en = wr && (sel == SEL_CTRL);
  assign char_d  = wdata[CHAR_W-1:0];
  assign ctrl_d  = prn_ctrl_t'(wdata[CTRL_W-1:0]);

  always_comb begin
    rvalid_d = 1'b0;
    rdata_d  = '0;
    if (rd) begin
      case (sel)
        SEL_CHAR: begin
          rvalid_d              = 1'b1;
          rdata_d[CHAR_W-1:0]   = char_q;
        end
        SEL_STAT: begin
          rvalid_d              = 1'b1;
          rdata_d[STAT_W-1:0]   = stat_sync;
        end
        SEL_CTRL: rvalid_d = 1'b1;
        default:  rvalid_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q   <= '0;
      ctrl_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (char_en) char_q <= char_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata    = rdata_q;
  assign rvalid   = rvalid_q;
  assign char_out = char_q;
  assign ctrl_out = ctrl_q;

  // R5 R8
  char_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_CHAR) |=> $stable(char_out));

  // R5 R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_CTRL) |=> $stable(ctrl_out));

  // R3
  char_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_CHAR) |=> (rvalid && rdata[CHAR_W-1:0] == $past(char_out)
                                 && rdata[DATA_W-1:CHAR_W] == '0));

  // R4
  stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_STAT) |=> (rvalid && rdata[DATA_W-1:STAT_W] == '0));

  // R7
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_CTRL) |=> (rvalid && rdata == '0));

  // R9
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd && sel != SEL_NONE));

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
endmodule

// File: rtl/prn_port.sv
module prn_port
  import prn_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter int                CHAR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_CHAR   = 16'hFFE0,
  parameter logic [ADDR_W-1:0] ADDR_STAT   = 16'hFFE2,
  parameter logic [ADDR_W-1:0] ADDR_CTRL   = 16'hFFE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [CHAR_W-1:0] prn_data,
  output logic              prn_strobe,
  output logic              prn_init,
  output logic              prn_select,
  input  logic              prn_ready_in,
  input  logic              prn_offline_in,
  input  logic              prn_paperout_in
);
  logic      rst_n_sync;
  prn_sel_e  sel;
  prn_stat_t stat_raw, stat_sync;
  prn_ctrl_t ctrl;

  assign stat_raw = '{paper_out: prn_paperout_in, offline: prn_offline_in, ready: prn_ready_in};

  prn_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  prn_decode #(
    .ADDR_W    (ADDR_W),
    .ADDR_CHAR (ADDR_CHAR),
    .ADDR_STAT (ADDR_STAT),
    .ADDR_CTRL (ADDR_CTRL)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  prn_sync #(
    .WIDTH  (STAT_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     (stat_raw),
    .q     (stat_sync)
  );

  prn_regs #(
    .DATA_W (DATA_W),
    .CHAR_W (CHAR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .sel       (sel),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .stat_sync (stat_sync),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .char_out  (prn_data),
    .ctrl_out  (ctrl)
  );

  assign prn_strobe = ctrl.strobe;
  assign prn_init   = ctrl.init;
  assign prn_select = ctrl.select;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_sync |-> (bus_rvalid == 1'b0 && prn_data == '0 && ctrl == '0));
endmodule

// File: tb/prn_port_test.sv
`timescale 1ns/1ps
module prn_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  prn_data;
  logic        prn_strobe, prn_init, prn_select;
  logic        prn_ready_in = 1'b0;
  logic        prn_offline_in = 1'b0;
  logic        prn_paperout_in = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int rcnt = 0;
  int m_char = 0, m_ctrl = 0, m_rdata = 0, m_rvalid = 0;
  int s1 = 0, s2 = 0;
  string rtag = "R9";

  always #10 clk = ~clk;

  prn_port uut (
    .clk (clk), .rst_n (rst_n),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wr (bus_wr), .bus_rd (bus_rd),
    .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .prn_data (prn_data), .prn_strobe (prn_strobe),
    .prn_init (prn_init), .prn_select (prn_select),
    .prn_ready_in (prn_ready_in), .prn_offline_in (prn_offline_in),
    .prn_paperout_in (prn_paperout_in)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; m_char = 0; m_ctrl = 0; m_rdata = 0; m_rvalid = 0; s1 = 0; s2 = 0;
      rtag = "R1";
    end else if (rcnt < 2) begin
      rcnt++;
      rtag = "R1";
    end else begin
      int nv, nd;
      nv = 0; nd = 0; rtag = "R9";
      if (bus_rd) begin
        if (bus_addr == 16'hFFE0) begin
          nv = 1; nd = m_char;
          rtag = (bus_wr) ? "R10" : "R3";
        end else if (bus_addr == 16'hFFE2) begin
          nv = 1; nd = s2; rtag = "R4";
        end else if (bus_addr == 16'hFFE8) begin
          nv = 1; nd = 0; rtag = "R7";
        end else rtag = "R8";
      end
      if (bus_wr) begin
        if (bus_addr == 16'hFFE0) m_char = bus_wdata & 16'hFF;
        else if (bus_addr == 16'hFFE8) m_ctrl = bus_wdata & 16'h7;
      end
      s2 = s1;
      s1 = {prn_paperout_in, prn_offline_in, prn_ready_in};
      m_rvalid = nv; m_rdata = nd;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2 prn_data", int'(prn_data), m_char);
      check("R6 control", int'({prn_select, prn_init, prn_strobe}), m_ctrl);
      check("R9 rvalid", int'(bus_rvalid), m_rvalid);
      check({rtag, " rdata"}, int'(bus_rdata), m_rdata);
    end
  end

  task automatic bus(input logic [15:0] a, input logic [15:0] d, input bit r, input bit w);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = r; bus_wr = w;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 reset", int'({bus_rvalid, prn_data, prn_strobe, prn_init, prn_select}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release", int'({prn_data, prn_strobe, prn_init, prn_select}), 0);

    bus(16'hFFE0, 16'h3CA5, 0, 1);          // R2 upper bits ignored
    bus(16'hFFE0, 16'h0000, 1, 0);          // R3 read back
    bus(16'hFFE0, 16'h0000, 1, 0);          // R3 read leaves latch alone
    bus(16'hFFE2, 16'hFFFF, 0, 1);          // R5 status write ignored
    bus(16'hFFE8, 16'hFFFD, 0, 1);          // R6 ctrl = 101
    bus(16'hFFE8, 16'h0000, 1, 0);          // R7 ctrl reads zero
    bus(16'hFFE8, 16'h0002, 0, 1);          // R6 init only

    @(negedge clk);
    prn_ready_in = 1; prn_paperout_in = 1;
    bus(16'hFFE2, 16'h0000, 1, 0);          // R4 too early: old value
    bus(16'hFFE2, 16'h0000, 1, 0);          // R4 now visible
    prn_offline_in = 1; prn_ready_in = 0;
    repeat (3) @(negedge clk);
    bus(16'hFFE2, 16'h0000, 1, 0);

    bus(16'hFFE1, 16'h0000, 1, 0);          // R8 near misses
    bus(16'hFFE4, 16'h0000, 1, 0);
    bus(16'hFFE9, 16'h0000, 1, 0);
    bus(16'h0000, 16'h0000, 1, 0);
    bus(16'hFFE1, 16'h00FF, 0, 1);
    bus(16'hFFE9, 16'h0007, 0, 1);

    bus(16'hFFE0, 16'h0042, 1, 1);          // R10 read old, store new
    bus(16'hFFE0, 16'h0000, 1, 0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: a = 16'hFFE0; 1: a = 16'hFFE2; 2: a = 16'hFFE8;
        3: a = 16'hFFE1; 4: a = 16'hFFEA; default: a = 16'($urandom);
      endcase
      @(negedge clk);
      bus_addr = a; bus_wdata = 16'($urandom);
      bus_rd = 1'($urandom); bus_wr = 1'($urandom);
      {prn_paperout_in, prn_offline_in, prn_ready_in} = 3'($urandom);
    end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule